// File: doc/BRIEF.md
# SPI Output Launch-Edge Selector

This block sits between the shift logic of an SPI target and its serial data pin. It decides whether each outgoing bit is launched on the rising or on the falling edge of the serial clock. It measures the serial clock period with a free-running reference clock and picks the rising edge for fast clocks and the falling edge for slow ones. A control byte can disable this automatic choice and force either edge. The same control byte carries a preamble-suppress flag. That flag is exported unchanged to a separate management-interface target and has no effect on SPI.

The period is the number of reference cycles between two rising serial-clock edges of the same transfer. It is taken from a two-flop synchronized copy of the clock. A measurement is kept pending while chip select is active and only takes effect once chip select goes inactive. The launch edge therefore never changes partway through a transfer. A hysteresis band around the threshold stops the choice from toggling when the clock period sits near the boundary.

Top module: `sdo_edge_sel`

## Requirements
- R1: After reset, the control byte at address 0x0100 reads 0x42: auto-select bit 1 is 1, manual-edge bit 0 is 0, preamble bit 2 is 0, and bits 7:3 are 01000b. preamble_sup_o is 0.
- R2: All eight control bits are writable and read back as written. A write to any other address leaves the byte unchanged, and a read of any other address returns 0x00.
- R3: preamble_sup_o follows control bit 2. Changing bit 2 does not change the SPI launch edge.
- R4: When bit 1 is 0, bit 0 selects the launch edge: 1 launches on the rising SCL edge and 0 on the falling edge.
- R5: When bit 1 is 1, bit 0 has no effect on the launch edge.
- R6: In auto mode, a measured period of THRESH_CNT-HYST_CNT reference cycles or fewer selects rising-edge launch. A period of THRESH_CNT+HYST_CNT or more selects falling-edge launch. A period strictly between the two keeps the previous choice.
- R7: The automatic choice changes only while chip select is inactive. Inside a transfer the launch edge stays as it was at the start, whatever the SCL rate.
- R8: Until the first valid measurement after reset, auto mode launches on the falling edge. A valid measurement is an interval between two rising SCL edges inside the same chip-select-active window.
- R9: While cs_ni is high, sdo_o is 0. sdo_oe_o is 0 as well, unless IDLE_DRIVE_LOW is set.
- R10: While cs_ni is low, sdo_oe_o is 1, and sdo_o shows the bit captured at the selected SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock used for measurement and register access |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data; 0 unless the address matches |
| scl_i | input | 1 | SPI serial clock |
| cs_ni | input | 1 | SPI chip select, active low |
| sdo_bit_i | input | 1 | Next serial output bit from the shift logic |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| preamble_sup_o | output | 1 | Preamble-suppress flag for the management-interface target |

## Verification
Some rules are checked by assertions on every reference cycle: the idle level and output enable of the data pin, the write-then-read behaviour of the control byte, the preamble flag holding between writes, the automatic choice staying fixed while chip select is active, and the falling-edge fallback before any measurement exists. Other behaviour can only be shown by the bench scenarios. These cover the SCL edge on which each bit appears, the hysteresis band with its dependence on history, the one-transfer lag before a new rate takes effect, and the manual override at both rates.

// File: rtl/sdo_edge_pkg.sv
`timescale 1ns/1ps
package sdo_edge_pkg;
  typedef struct packed {
    logic [4:0] rsvd;
    logic       pre_sup;
    logic       auto_en;
    logic       rise_man;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h42;
endpackage

// File: rtl/edge_ctrl_reg.sv
`timescale 1ns/1ps
module edge_ctrl_reg
  import sdo_edge_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CTRL_ADDR = 16'h0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output ctrl_t             ctrl_o
);
  localparam logic [ADDR_W-1:0] ADDR_HIT = ADDR_W'(CTRL_ADDR);

  logic hit;
  assign hit = (addr_i == ADDR_HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= ctrl_t'(CTRL_RST);
    else if (we_i && hit) ctrl_o <= ctrl_t'(wdata_i);
  end

  assign rdata_o = hit ? 8'(ctrl_o) : 8'h00;
endmodule

// File: rtl/scl_rate_meter.sv
`timescale 1ns/1ps
module scl_rate_meter #(
  parameter int CNT_MAX = 36,
  parameter int CNT_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             cs_ni,
  output logic             cs_idle_o,
  output logic             per_vld_o,
  output logic [CNT_W-1:0] per_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

  logic [1:0]       scl_s, cs_s;
  logic             scl_d, armed;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= 2'b00;
      cs_s  <= 2'b11;
      scl_d <= 1'b0;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      cs_s  <= {cs_s[0], cs_ni};
      scl_d <= scl_s[1];
    end
  end

  assign rise      = scl_s[1] & ~scl_d;
  assign cs_idle_o = cs_s[1];

  // intervals crossing an idle window are discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt       <= '0;
      armed     <= 1'b0;
      per_vld_o <= 1'b0;
      per_o     <= '0;
    end else begin
      per_vld_o <= 1'b0;
      if (cs_idle_o) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (rise) begin
        if (armed) begin
          per_o     <= cnt;
          per_vld_o <= 1'b1;
        end
        armed <= 1'b1;
        cnt   <= CNT_W'(1);
      end else if (cnt != SAT) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_decider.sv
`timescale 1ns/1ps
module edge_decider #(
  parameter int THRESH_CNT = 8,
  parameter int HYST_CNT   = 1,
  parameter int CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_idle_i,
  input  logic             per_vld_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             fast_o,
  output logic             have_o
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(THRESH_CNT - HYST_CNT);
  localparam logic [CNT_W-1:0] HI = CNT_W'(THRESH_CNT + HYST_CNT);

  logic [CNT_W-1:0] pend_per;
  logic             pend_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_per <= '0;
      pend_vld <= 1'b0;
      fast_o   <= 1'b0;
      have_o   <= 1'b0;
    end else begin
      if (cs_idle_i && pend_vld) begin
        pend_vld <= 1'b0;
        have_o   <= 1'b1;
        if (pend_per <= LO)      fast_o <= 1'b1;
        else if (pend_per >= HI) fast_o <= 1'b0;
      end
      if (per_vld_i) begin
        pend_per <= per_i;
        pend_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdo_launch.sv
`timescale 1ns/1ps
module sdo_launch (
  input  logic rst_ni,
  input  logic scl_i,
  input  logic cs_ni,
  input  logic bit_i,
  input  logic rise_sel_i,
  output logic sdo_o
);
  logic q_rise, q_fall;

  always_ff @(posedge scl_i or negedge rst_ni) begin
    if (!rst_ni) q_rise <= 1'b0;
    else         q_rise <= bit_i;
  end

  always_ff @(negedge scl_i or negedge rst_ni) begin
    if (!rst_ni) q_fall <= 1'b0;
    else         q_fall <= bit_i;
  end

  assign sdo_o = cs_ni ? 1'b0 : (rise_sel_i ? q_rise : q_fall);
endmodule

// File: rtl/sdo_edge_sel.sv
`timescale 1ns/1ps
module sdo_edge_sel
  import sdo_edge_pkg::*;
#(
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] CTRL_ADDR      = 16'h0100,
  parameter int          THRESH_CNT     = 8,
  parameter int          HYST_CNT       = 1,
  parameter bit          IDLE_DRIVE_LOW = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              scl_i,
  input  logic              cs_ni,
  input  logic              sdo_bit_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              preamble_sup_o
);
  localparam int CNT_MAX = 2 * (THRESH_CNT + HYST_CNT);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctrl_t            ctrl;
  logic             cs_idle, per_vld, auto_fast, have_meas, rise_sel;
  logic [CNT_W-1:0] per;

  edge_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .ctrl_o(ctrl)
  );

  scl_rate_meter #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_meter (
    .clk_i, .rst_ni, .scl_i, .cs_ni,
    .cs_idle_o(cs_idle), .per_vld_o(per_vld), .per_o(per)
  );

  edge_decider #(.THRESH_CNT(THRESH_CNT), .HYST_CNT(HYST_CNT), .CNT_W(CNT_W)) u_dec (
    .clk_i, .rst_ni, .cs_idle_i(cs_idle), .per_vld_i(per_vld), .per_i(per),
    .fast_o(auto_fast), .have_o(have_meas)
  );

  assign rise_sel = ctrl.auto_en ? auto_fast : ctrl.rise_man;

  sdo_launch u_launch (
    .rst_ni, .scl_i, .cs_ni, .bit_i(sdo_bit_i), .rise_sel_i(rise_sel), .sdo_o
  );

  assign sdo_oe_o       = ~cs_ni | IDLE_DRIVE_LOW;
  assign preamble_sup_o = ctrl.pre_sup;
endmodule

// File: rtl/sdo_edge_sel_chk.sv
`timescale 1ns/1ps
module sdo_edge_sel_chk #(
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] CTRL_ADDR      = 16'h0100,
  parameter bit          IDLE_DRIVE_LOW = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic              cs_ni,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              preamble_sup_o,
  input logic              cs_idle,
  input logic              auto_fast,
  input logic              have_meas
);
  localparam logic [ADDR_W-1:0] A = ADDR_W'(CTRL_ADDR);

  a_r2_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A) ##1 (reg_addr_i == A) |-> reg_rdata_o == $past(reg_wdata_i));

  a_r3_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(preamble_sup_o));

  a_r7_no_switch_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_idle && !$past(cs_idle)) |-> $stable(auto_fast));

  a_r8_fallback_falling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !have_meas |-> !auto_fast);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (!sdo_o && (IDLE_DRIVE_LOW || !sdo_oe_o)));

  a_r10_active_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |-> sdo_oe_o);
endmodule

bind sdo_edge_sel sdo_edge_sel_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .IDLE_DRIVE_LOW(IDLE_DRIVE_LOW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .cs_ni(cs_ni),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .preamble_sup_o(preamble_sup_o),
  .cs_idle(cs_idle), .auto_fast(auto_fast), .have_meas(have_meas)
);

// File: tb/sdo_edge_sel_bench.sv
`timescale 1ns/1ps
module sdo_edge_sel_bench;
  localparam int T_CNT = 16;
  localparam int H_CNT = 2;
  localparam int FAST_HALF = 50;   // 10 ref cycles
  localparam int SLOW_HALF = 150;  // 30 ref cycles
  localparam int BAND_HALF = 80;   // 16 ref cycles, inside band

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_addr_i = 16'h0100;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [7:0]  reg_rdata_o;
  logic        scl_i = 1'b0, cs_ni = 1'b1, sdo_bit_i = 1'b0;
  logic        sdo_o, sdo_oe_o, preamble_sup_o;

  int n_vec = 0, n_bad = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    prev_bit = 1'b0;

  always #5 clk_i = ~clk_i;

  sdo_edge_sel #(.THRESH_CNT(T_CNT), .HYST_CNT(H_CNT)) u_sdo_edge_sel (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .scl_i, .cs_ni, .sdo_bit_i, .sdo_o, .sdo_oe_o, .preamble_sup_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = 16'h0100;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 chk(reg_rdata_o == e, tag, reg_rdata_o, e);
    reg_addr_i = 16'h0100;
  endtask

  // driver: pushes the value sdo_o must show just after each SCL rise
  task automatic xfer(input int half, input logic [7:0] pat, input bit rise, input string tag);
    @(negedge clk_i);
    cs_ni = 1'b0;
    #1 chk(sdo_oe_o == 1'b1, "R10 oe active", sdo_oe_o, 1);
    #(half - 1);
    for (int i = 7; i >= 0; i--) begin
      sdo_bit_i = pat[i];
      exp_q.push_back(rise ? pat[i] : prev_bit);
      tag_q.push_back(tag);
      prev_bit = pat[i];
      scl_i = 1'b1;
      #half;
      scl_i = 1'b0;
      #half;
    end
    cs_ni = 1'b1;
    #1 chk(sdo_o == 1'b0 && sdo_oe_o == 1'b0, "R9 idle", {sdo_oe_o, sdo_o}, 0);
    #199;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge scl_i);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(sdo_o == e, t, sdo_o, e);
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #23 rst_ni = 1'b1;
    #1 chk(reg_rdata_o == 8'h42, "R1 reset value", reg_rdata_o, 8'h42);
    chk(preamble_sup_o == 1'b0, "R1 preamble reset", preamble_sup_o, 0);
    chk(sdo_o == 1'b0 && sdo_oe_o == 1'b0, "R9 idle after reset", {sdo_oe_o, sdo_o}, 0);

    xfer(FAST_HALF, 8'hA5, 1'b0, "R8 fallback falling");
    xfer(FAST_HALF, 8'h3C, 1'b1, "R6 fast rising");
    xfer(SLOW_HALF, 8'h96, 1'b1, "R7 held inside transfer");
    xfer(SLOW_HALF, 8'h5A, 1'b0, "R6 slow falling");
    xfer(BAND_HALF, 8'hC3, 1'b0, "R6 band holds falling");
    xfer(BAND_HALF, 8'h69, 1'b0, "R6 band holds falling again");
    xfer(FAST_HALF, 8'hB4, 1'b0, "R7 fast seen, not yet applied");
    xfer(BAND_HALF, 8'h2D, 1'b1, "R6 rising after fast");
    xfer(BAND_HALF, 8'hE1, 1'b1, "R6 band holds rising");

    wr(16'h0100, 8'h43);
    rd(16'h0100, 8'h43, "R2 readback 43");
    xfer(SLOW_HALF, 8'h55, 1'b1, "R5 auto still rising");
    xfer(SLOW_HALF, 8'hAA, 1'b0, "R5 bit0 ignored in auto");

    wr(16'h0100, 8'h41);
    xfer(SLOW_HALF, 8'h5A, 1'b1, "R4 manual rising at slow rate");
    wr(16'h0100, 8'h40);
    xfer(FAST_HALF, 8'hA5, 1'b0, "R4 manual falling at fast rate");

    wr(16'h0100, 8'h44);
    #1 chk(preamble_sup_o == 1'b1, "R3 preamble set", preamble_sup_o, 1);
    xfer(FAST_HALF, 8'h96, 1'b0, "R3 edge unaffected by preamble");
    wr(16'h0100, 8'h45);
    xfer(FAST_HALF, 8'h69, 1'b1, "R3 manual rising with preamble");

    wr(16'h0100, 8'hFF);
    rd(16'h0100, 8'hFF, "R2 all bits writable");
    wr(16'h0101, 8'h00);
    rd(16'h0100, 8'hFF, "R2 other address ignored");
    rd(16'h0101, 8'h00, "R2 other address reads zero");
    chk(preamble_sup_o == 1'b1, "R2 flag unchanged by stray write", preamble_sup_o, 1);
    wr(16'h0100, 8'h02);
    #1 chk(preamble_sup_o == 1'b0, "R3 preamble cleared", preamble_sup_o, 0);

    #100;
    chk(exp_q.size() == 0, "R10 all bits observed", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule